// File: doc/BRIEF.md
# Slave-Select Polarity and Override Unit

This unit drives the slave-select lines of a serial peripheral master. The transfer engine tells it which slave it is addressing and whether a transfer is running. The unit turns that into one registered select output per line. Each line has its own active level, given by a polarity bit.

Software can take any single line away from the engine through an override register. That register holds, for each line, an enable bit and a forced level. A global control word holds three more settings:
- a bit that stops the serial clock while no slave is selected;
- the idle level of the serial clock;
- the idle level of the data-out line.

All outputs come from flops, so they change only on a clock edge.

Top module: `cs_polarity_unit`

## Requirements
- R1: After reset every cs_o line is 1, sclk_en_o is 1, and sclk_idle_o and mosi_idle_o are 0. In that state all polarity bits are 0 (active-low) and all overrides are disabled.
- R2: When eng_active_i is 1 and line eng_sel_i is not overridden, that line is driven to its polarity bit on the clock edge after the inputs are sampled.
- R3: A line that is neither selected by the engine nor overridden is driven to the inverse of its polarity bit.
- R4: Bits [7:0] of a global control write are the polarity bits, one per line (bit i for line i). A 1 makes the line active-high and a 0 makes it active-low.
- R5: In an override write, bits [7:0] are the per-line enables and bits [15:8] are the per-line levels (bit 8+i for line i). An enabled line is driven to its level whatever the engine inputs are.
- R6: When global control bit 16 is 1 and no cs_o line is at its active level, sclk_en_o is 0. In every other case sclk_en_o is 1.
- R7: Global control bit 17 drives sclk_idle_o and bit 18 drives mosi_idle_o.
- R8: A register write reaches cs_o and sclk_en_o on the second clock edge after the write is sampled. It reaches sclk_idle_o and mosi_idle_o on the first edge. A change on the engine inputs reaches cs_o on the first edge.
- R9: While eng_active_i is 0, no line that is not overridden is at its active level, whatever the value of eng_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eng_active_i | input | 1 | Engine transfer in progress |
| eng_sel_i | input | 3 | Engine target slave index |
| glb_we_i | input | 1 | Global control write strobe |
| glb_wdata_i | input | 32 | Global control write data |
| ovr_we_i | input | 1 | Override register write strobe |
| ovr_wdata_i | input | 32 | Override register write data |
| cs_o | output | 8 | Slave-select lines |
| sclk_en_o | output | 1 | Serial clock enable |
| sclk_idle_o | output | 1 | Serial clock idle level |
| mosi_idle_o | output | 1 | Data-out idle level |

## Verification
A corrupted polarity or override flop shows up on cs_o as a line at the wrong level. This is visible on the second edge after the write, and it stays visible for as long as the register keeps that value. A faulty line decoder shows up as two lines asserted at once, or as a line asserted while no transfer is active, one edge after the engine inputs change. The bench sweeps random configurations and engine states for this reason, and it compares all lines after every step. A stale view of "no slave selected" shows up as sclk_en_o disagreeing with the cs_o value sampled in the same cycle.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned NUM_CS   = 8;
  localparam int unsigned SEL_W    = $clog2(NUM_CS);
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned GATE_BIT = 16;
  localparam int unsigned CKPL_BIT = 17;
  localparam int unsigned MOSI_BIT = 18;
  localparam int unsigned LVL_LSB  = 8;

  typedef struct packed {
    logic [NUM_CS-1:0] pol;
    logic              gate;
    logic              sclk_idle;
    logic              mosi_idle;
  } glb_cfg_t;

  typedef struct packed {
    logic [NUM_CS-1:0] en;
    logic [NUM_CS-1:0] lvl;
  } ovr_cfg_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int unsigned N  = NUM_CS,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          glb_we_i,
  input  logic [DW-1:0] glb_wdata_i,
  input  logic          ovr_we_i,
  input  logic [DW-1:0] ovr_wdata_i,
  output logic [N-1:0]  pol_o,
  output logic          gate_o,
  output logic          sclk_idle_o,
  output logic          mosi_idle_o,
  output logic [N-1:0]  ovr_en_o,
  output logic [N-1:0]  ovr_lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o       <= '0;
      gate_o      <= 1'b0;
      sclk_idle_o <= 1'b0;
      mosi_idle_o <= 1'b0;
    end else if (glb_we_i) begin
      pol_o       <= glb_wdata_i[N-1:0];
      gate_o      <= glb_wdata_i[GATE_BIT];
      sclk_idle_o <= glb_wdata_i[CKPL_BIT];
      mosi_idle_o <= glb_wdata_i[MOSI_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_en_o  <= '0;
      ovr_lvl_o <= '0;
    end else if (ovr_we_i) begin
      ovr_en_o  <= ovr_wdata_i[N-1:0];
      ovr_lvl_o <= ovr_wdata_i[LVL_LSB+N-1:LVL_LSB];
    end
  end
endmodule

// File: rtl/cs_line_drv.sv
module cs_line_drv #(
  parameter int unsigned IDX   = 0,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eng_active_i,
  input  logic [SEL_W-1:0] eng_sel_i,
  input  logic             pol_i,
  input  logic             ovr_en_i,
  input  logic             ovr_lvl_i,
  output logic             cs_o,
  output logic             asserted_o
);
  logic hit;
  logic cs_d;

  assign hit = eng_active_i && (eng_sel_i == SEL_W'(IDX));

  always_comb begin
    if (ovr_en_i)  cs_d = ovr_lvl_i;
    else if (hit)  cs_d = pol_i;
    else           cs_d = ~pol_i;
  end

  // next-cycle "line at active level", used by clock gating
  assign asserted_o = (cs_d == pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_o <= 1'b1;
    else         cs_o <= cs_d;
  end
endmodule

// File: rtl/cs_clk_ctrl.sv
module cs_clk_ctrl #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  logic [N-1:0] asserted_i,
  output logic         sclk_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_en_o <= 1'b1;
    else         sclk_en_o <= !(gate_i && (asserted_i == '0));
  end
endmodule

// File: rtl/cs_polarity_unit.sv
module cs_polarity_unit
  import cs_pkg::*;
#(
  parameter int unsigned N  = NUM_CS,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eng_active_i,
  input  logic [SW-1:0] eng_sel_i,
  input  logic          glb_we_i,
  input  logic [DW-1:0] glb_wdata_i,
  input  logic          ovr_we_i,
  input  logic [DW-1:0] ovr_wdata_i,
  output logic [N-1:0]  cs_o,
  output logic          sclk_en_o,
  output logic          sclk_idle_o,
  output logic          mosi_idle_o
);
  logic [N-1:0] pol_q, ovr_en_q, ovr_lvl_q, asserted;
  logic         gate_q;

  cs_cfg_regs #(.N(N), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .glb_we_i, .glb_wdata_i, .ovr_we_i, .ovr_wdata_i,
    .pol_o(pol_q), .gate_o(gate_q), .sclk_idle_o, .mosi_idle_o,
    .ovr_en_o(ovr_en_q), .ovr_lvl_o(ovr_lvl_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    cs_line_drv #(.IDX(i), .SEL_W(SW)) u_line (
      .clk_i, .rst_ni, .eng_active_i, .eng_sel_i,
      .pol_i(pol_q[i]), .ovr_en_i(ovr_en_q[i]), .ovr_lvl_i(ovr_lvl_q[i]),
      .cs_o(cs_o[i]), .asserted_o(asserted[i])
    );
  end

  cs_clk_ctrl #(.N(N)) u_clk (
    .clk_i, .rst_ni, .gate_i(gate_q), .asserted_i(asserted), .sclk_en_o
  );
endmodule

// File: rtl/cs_polarity_unit_chk.sv
module cs_polarity_unit_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          eng_active_i,
  input logic [SW-1:0] eng_sel_i,
  input logic [N-1:0]  cs_o,
  input logic          sclk_en_o,
  input logic [N-1:0]  pol_q,
  input logic [N-1:0]  ovr_en_q,
  input logic [N-1:0]  ovr_lvl_q,
  input logic          gate_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_override_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (((cs_o ^ $past(ovr_lvl_q)) & $past(ovr_en_q)) == '0));

  p_single_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> $onehot0(~(cs_o ^ $past(pol_q)) & ~$past(ovr_en_q)));

  p_idle_lines_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(eng_active_i)) |-> ((~(cs_o ^ $past(pol_q)) & ~$past(ovr_en_q)) == '0));

  p_gate_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(gate_q) && ((~(cs_o ^ $past(pol_q))) == '0)) |-> !sclk_en_o);

  p_gate_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(gate_q)) |-> sclk_en_o);
endmodule

bind cs_polarity_unit cs_polarity_unit_chk #(.N(N), .SW(SW)) u_chk (
  .clk_i, .rst_ni, .eng_active_i, .eng_sel_i, .cs_o, .sclk_en_o,
  .pol_q, .ovr_en_q, .ovr_lvl_q, .gate_q
);

// File: tb/cs_polarity_unit_bench.sv
`timescale 1ns/1ps
module cs_polarity_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act = 1'b0;
  logic [2:0]  sel = '0;
  logic        gwe = 1'b0, owe = 1'b0;
  logic [31:0] gwd = '0, owd = '0;
  logic [7:0]  cs;
  logic        sen, sidle, midle;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_glb = '0, m_ovr = '0;

  always #2.5 clk = ~clk;

  cs_polarity_unit u_cs_polarity_unit (
    .clk_i(clk), .rst_ni(rst_n), .eng_active_i(act), .eng_sel_i(sel),
    .glb_we_i(gwe), .glb_wdata_i(gwd), .ovr_we_i(owe), .ovr_wdata_i(owd),
    .cs_o(cs), .sclk_en_o(sen), .sclk_idle_o(sidle), .mosi_idle_o(midle)
  );

  function automatic logic [7:0] exp_cs(logic [31:0] g, logic [31:0] o, logic a, logic [2:0] s);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (o[i])               r[i] = o[8+i];
      else if (a && s == i)   r[i] = g[i];
      else                    r[i] = ~g[i];
    end
    return r;
  endfunction

  function automatic logic exp_sen(logic [31:0] g, logic [7:0] c);
    return !(g[16] && ((~(c ^ g[7:0])) == 8'h00));
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(logic [31:0] g, logic gw, logic [31:0] o, logic ow, logic a, logic [2:0] s);
    @(negedge clk);
    gwe = gw; gwd = g; owe = ow; owd = o; act = a; sel = s;
    if (gw) m_glb = g;
    if (ow) m_ovr = o;
    @(negedge clk);
    gwe = 1'b0; owe = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] e;
    e = exp_cs(m_glb, m_ovr, act, sel);
    chk({tag, " cs"}, 32'(cs), 32'(e));
    chk("R6 sclk_en", 32'(sen), 32'(exp_sen(m_glb, e)));
    chk("R7 idle", {30'd0, midle, sidle}, {30'd0, m_glb[18], m_glb[17]});
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset cs", 32'(cs), 32'hff);
    chk("R1 reset sen", 32'(sen), 32'd1);
    chk("R1 reset idle", {30'd0, midle, sidle}, 32'd0);
    rst_n = 1'b1;

    // R2/R3 active-low select of line 5
    step(32'h0, 1'b0, 32'h0, 1'b0, 1'b1, 3'd5);
    chk("R2 sel5 low", 32'(cs), 32'hdf);
    // R9: inactive with any index leaves all deasserted
    step(32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 3'd2);
    chk("R9 inactive", 32'(cs), 32'hff);
    // R4 active-high on line 2 only
    step(32'h0000_0004, 1'b1, 32'h0, 1'b0, 1'b1, 3'd2);
    chk("R4 pol2 high", 32'(cs), 32'hff);
    step(32'h0000_0004, 1'b1, 32'h0, 1'b0, 1'b1, 3'd3);
    chk("R3 others inverse", 32'(cs), 32'hf3);
    // R5 override beats engine: force line 3 high, line 0 low
    step(32'h0000_0004, 1'b0, 32'h0000_0809, 1'b1, 1'b1, 3'd3);
    chk("R5 override", 32'(cs), 32'hfa);
    // R6 gate with nothing selected
    step(32'h0001_0000, 1'b1, 32'h0, 1'b1, 1'b0, 3'd0);
    chk("R6 gated off", 32'(sen), 32'd0);
    step(32'h0001_0000, 1'b0, 32'h0, 1'b0, 1'b1, 3'd7);
    chk("R6 gated on", 32'(sen), 32'd1);
    // R7 idle levels
    step(32'h0006_0000, 1'b1, 32'h0, 1'b0, 1'b0, 3'd0);
    chk("R7 idle bits", {30'd0, midle, sidle}, 32'd3);

    // R8 latency: polarity write visible on second edge only
    @(negedge clk);
    gwe = 1'b1; gwd = 32'h0000_00ff; act = 1'b0;
    @(negedge clk);
    gwe = 1'b0;
    chk("R8 one edge old", 32'(cs), 32'hff);
    chk("R8 idle one edge", {30'd0, midle, sidle}, 32'd0);
    @(negedge clk);
    chk("R8 two edges new", 32'(cs), 32'h00);
    m_glb = 32'h0000_00ff;
    // engine latency one edge
    @(negedge clk);
    act = 1'b1; sel = 3'd4;
    @(negedge clk);
    chk("R8 engine one edge", 32'(cs), 32'h10);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] g, o;
      g = $urandom & 32'h0007_00ff;
      o = $urandom & 32'h0000_ffff;
      if (($urandom % 3) == 0) o = '0;
      step(g, ($urandom % 2) == 1, o, ($urandom % 2) == 1,
           ($urandom % 4) != 0, 3'($urandom));
      check_all("R2 R3 R5 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule